// File: doc/BRIEF.md
# Two-channel external interrupt controller

This block turns activity on a small set of external request pins into interrupt requests for a CPU core. Each pin is first brought into the clock domain through a synchroniser. It is then compared against a per-channel sense mode, which selects low level, any change, falling edge or rising edge. In the three edge-type modes a matching event latches a pending flag. In low-level mode the request tracks the pin directly and nothing is latched.

Software sets up the block through a byte-wide register port. Three registers are reached this way: a sense-control register, a mask register and a pending register. A request leaves the block only when its channel is unmasked and the global interrupt-enable input is high. A pending flag is cleared in one of two ways: software writes a one to its bit, or the core pulses the acknowledge input with that channel's index. A new qualifying event in the same cycle always wins over a clear. Since the block only watches pin levels, software that drives a pin as an output can raise an interrupt by toggling it.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, the sense-control (address 0), mask (address 1) and pending (address 2) registers all read 0x00, and no request is raised.
- R2: With sense code 2'b00, the request follows the inverted synchronised pin: it is high while the pin is low and drops once the pin is high again. The pending bit reads 0 in this mode.
- R3: With sense code 2'b01, both a falling and a rising transition set the pending flag.
- R4: With sense code 2'b10, a falling transition sets the pending flag and a rising transition does not.
- R5: With sense code 2'b11, a rising transition sets the pending flag and a falling transition does not.
- R6: Bit n of the request output is high only when mask bit n is one and the global enable input is one. A pending flag survives while its request is gated off.
- R7: A write to the pending register clears each flag whose data bit is one. Flags whose data bit is zero are left unchanged.
- R8: Channel n's sense code sits in bits [2n+1:2n] of the sense-control register. Mask and pending bit n sit in bit n. All bits above the channels read as zero and ignore writes.
- R9: A one-cycle pulse on the acknowledge input clears the pending flag of the channel named by the acknowledge index. Other channels are left untouched.
- R10: If an acknowledge and a qualifying event for the same channel fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_CH | Raw external request pins |
| glb_ie_i | input | 1 | Global interrupt enable from the core |
| reg_addr_i | input | ADDR_W | Register address (0 sense, 1 mask, 2 pending) |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for the current address |
| ack_i | input | 1 | Vector acknowledge pulse |
| ack_ch_i | input | CH_IDX_W | Channel index carried by the acknowledge |
| irq_o | output | NUM_CH | Per-channel gated interrupt requests |

## Verification
The pins are driven through falling and rising transitions under each of the four sense codes. This shows which transitions latch a flag and which are ignored: the rising edge under falling sense, and the falling edge under rising sense. Level mode is tried by holding the pin low and then releasing it, which separates a following request from a latched one. The clear paths are exercised separately: zero-bit writes, one-bit writes, an acknowledge aimed at the other channel, and an acknowledge timed to land in the same cycle as a fresh edge. Gating is tried with a pending flag present, while the mask and the global enable are each turned off in turn.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

   typedef enum logic [1:0] {
      SNS_LOW  = 2'b00,
      SNS_ANY  = 2'b01,
      SNS_FALL = 2'b10,
      SNS_RISE = 2'b11
   } sense_t;

   localparam int unsigned REG_SENSE = 0;
   localparam int unsigned REG_MASK  = 1;
   localparam int unsigned REG_FLAG  = 2;

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("eirq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
   import eirq_pkg::*;
#(
   parameter logic RST_VAL = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   pin_s_i,
   input  sense_t mode_i,
   output logic   evt_o,
   output logic   lvl_o
);

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= RST_VAL;
      end else begin
         prev_q <= pin_s_i;
      end
   end

   logic rise_w;
   logic fall_w;

   assign rise_w = pin_s_i & ~prev_q;
   assign fall_w = ~pin_s_i & prev_q;

   always_comb begin
      unique case (mode_i)
         SNS_LOW:  evt_o = 1'b0;
         SNS_ANY:  evt_o = rise_w | fall_w;
         SNS_FALL: evt_o = fall_w;
         SNS_RISE: evt_o = rise_w;
         default:  evt_o = 1'b0;
      endcase
   end

   assign lvl_o = (mode_i == SNS_LOW) & ~pin_s_i;

endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
   import eirq_pkg::*;
#(
   parameter int unsigned NUM_CH   = 2,
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned CH_IDX_W = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic                we_i,
   input  logic [DATA_W-1:0]   wdata_i,
   output logic [DATA_W-1:0]   rdata_o,
   input  logic                ack_i,
   input  logic [CH_IDX_W-1:0] ack_ch_i,
   input  logic                gie_i,
   input  logic [NUM_CH-1:0]   evt_i,
   input  logic [NUM_CH-1:0]   lvl_i,
   output logic [2*NUM_CH-1:0] sense_o,
   output logic [NUM_CH-1:0]   mask_o,
   output logic [NUM_CH-1:0]   flag_o,
   output logic [NUM_CH-1:0]   irq_o
);

   localparam int unsigned SNS_W = 2 * NUM_CH;

   logic [SNS_W-1:0]  sense_q;
   logic [NUM_CH-1:0] mask_q;
   logic [NUM_CH-1:0] flag_q;
   logic [NUM_CH-1:0] flag_d;
   logic [NUM_CH-1:0] clr_w;
   logic [NUM_CH-1:0] is_low_w;

   logic wr_sense;
   logic wr_mask;
   logic wr_flag;

   assign wr_sense = we_i && (addr_i == ADDR_W'(REG_SENSE));
   assign wr_mask  = we_i && (addr_i == ADDR_W'(REG_MASK));
   assign wr_flag  = we_i && (addr_i == ADDR_W'(REG_FLAG));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign is_low_w[c] = (sense_t'(sense_q[2*c +: 2]) == SNS_LOW);
      assign clr_w[c]    = (wr_flag && wdata_i[c]) ||
                           (ack_i && (ack_ch_i == CH_IDX_W'(c)));

      always_comb begin
         if (is_low_w[c]) begin
            flag_d[c] = 1'b0;
         end else if (evt_i[c]) begin
            flag_d[c] = 1'b1;
         end else if (clr_w[c]) begin
            flag_d[c] = 1'b0;
         end else begin
            flag_d[c] = flag_q[c];
         end
      end

      assign irq_o[c] = gie_i & mask_q[c] & (is_low_w[c] ? lvl_i[c] : flag_q[c]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sense_q <= '0;
         mask_q  <= '0;
         flag_q  <= '0;
      end else begin
         if (wr_sense) sense_q <= wdata_i[SNS_W-1:0];
         if (wr_mask)  mask_q  <= wdata_i[NUM_CH-1:0];
         flag_q <= flag_d;
      end
   end

   always_comb begin
      rdata_o = '0;
      unique case (int'(addr_i))
         REG_SENSE: rdata_o[SNS_W-1:0]  = sense_q;
         REG_MASK:  rdata_o[NUM_CH-1:0] = mask_q;
         REG_FLAG:  rdata_o[NUM_CH-1:0] = flag_q;
         default:   rdata_o = '0;
      endcase
   end

   assign sense_o = sense_q;
   assign mask_o  = mask_q;
   assign flag_o  = flag_q;

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
   import eirq_pkg::*;
#(
   parameter int unsigned NUM_CH      = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned DATA_W      = 8,
   parameter logic        PIN_IDLE    = 1'b1,
   localparam int unsigned CH_IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_CH-1:0]   pin_i,
   input  logic                glb_ie_i,
   input  logic [ADDR_W-1:0]   reg_addr_i,
   input  logic                reg_we_i,
   input  logic [DATA_W-1:0]   reg_wdata_i,
   output logic [DATA_W-1:0]   reg_rdata_o,
   input  logic                ack_i,
   input  logic [CH_IDX_W-1:0] ack_ch_i,
   output logic [NUM_CH-1:0]   irq_o
);

   if (NUM_CH < 1 || 2 * NUM_CH > DATA_W) begin : g_bad_ch
      $error("ext_irq_ctrl: sense fields of all channels must fit in DATA_W");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ext_irq_ctrl: ADDR_W must reach three registers");
   end

   logic [NUM_CH-1:0]   pin_s;
   logic [NUM_CH-1:0]   evt;
   logic [NUM_CH-1:0]   lvl;
   logic [2*NUM_CH-1:0] sense_flat;
   logic [NUM_CH-1:0]   mask_q;
   logic [NUM_CH-1:0]   flag_q;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      eirq_sync #(
         .STAGES  (SYNC_STAGES),
         .RST_VAL (PIN_IDLE)
      ) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d_i   (pin_i[c]),
         .q_o   (pin_s[c])
      );

      eirq_detect #(
         .RST_VAL (PIN_IDLE)
      ) u_det (
         .clk     (clk),
         .rst_n   (rst_n),
         .pin_s_i (pin_s[c]),
         .mode_i  (sense_t'(sense_flat[2*c +: 2])),
         .evt_o   (evt[c]),
         .lvl_o   (lvl[c])
      );
   end

   eirq_regs #(
      .NUM_CH   (NUM_CH),
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .CH_IDX_W (CH_IDX_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_i   (reg_addr_i),
      .we_i     (reg_we_i),
      .wdata_i  (reg_wdata_i),
      .rdata_o  (reg_rdata_o),
      .ack_i    (ack_i),
      .ack_ch_i (ack_ch_i),
      .gie_i    (glb_ie_i),
      .evt_i    (evt),
      .lvl_i    (lvl),
      .sense_o  (sense_flat),
      .mask_o   (mask_q),
      .flag_o   (flag_q),
      .irq_o    (irq_o)
   );

endmodule

// File: rtl/eirq_checker.sv
module eirq_checker
   import eirq_pkg::*;
#(
   parameter int unsigned NUM_CH   = 2,
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned CH_IDX_W = 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                glb_ie_i,
   input logic [ADDR_W-1:0]   reg_addr_i,
   input logic                reg_we_i,
   input logic [DATA_W-1:0]   reg_wdata_i,
   input logic [DATA_W-1:0]   reg_rdata_o,
   input logic                ack_i,
   input logic [CH_IDX_W-1:0] ack_ch_i,
   input logic [NUM_CH-1:0]   irq_o,
   input logic [NUM_CH-1:0]   evt,
   input logic [2*NUM_CH-1:0] sense_flat,
   input logic [NUM_CH-1:0]   mask_q,
   input logic [NUM_CH-1:0]   flag_q
);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_c
      logic is_low;
      logic ack_me;
      assign is_low = (sense_flat[2*c +: 2] == 2'b00);
      assign ack_me = ack_i && (ack_ch_i == CH_IDX_W'(c));

      // R6
      irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o[c] |-> (glb_ie_i && mask_q[c]));

      // R2
      level_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
         is_low |=> !flag_q[c]);

      // R7
      zero_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_we_i && reg_addr_i == ADDR_W'(REG_FLAG) && !reg_wdata_i[c] &&
          !ack_me && flag_q[c] && !is_low) |=> flag_q[c]);

      // R10
      ack_collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_me && evt[c]) |=> flag_q[c]);

      // R4 R5
      no_spurious_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!flag_q[c] && !evt[c]) |=> !flag_q[c]);
   end

   if (DATA_W > NUM_CH) begin : g_rsv
      // R8
      reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_addr_i == ADDR_W'(REG_MASK) || reg_addr_i == ADDR_W'(REG_FLAG))
            |-> (reg_rdata_o[DATA_W-1:NUM_CH] == '0));
   end

endmodule

bind ext_irq_ctrl eirq_checker #(
   .NUM_CH   (NUM_CH),
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .CH_IDX_W (CH_IDX_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .glb_ie_i    (glb_ie_i),
   .reg_addr_i  (reg_addr_i),
   .reg_we_i    (reg_we_i),
   .reg_wdata_i (reg_wdata_i),
   .reg_rdata_o (reg_rdata_o),
   .ack_i       (ack_i),
   .ack_ch_i    (ack_ch_i),
   .irq_o       (irq_o),
   .evt         (evt),
   .sense_flat  (sense_flat),
   .mask_q      (mask_q),
   .flag_q      (flag_q)
);

// File: tb/sim_ext_irq_ctrl.sv
module sim_ext_irq_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] pin = 2'b11;
   logic       gie = 1'b0;
   logic [1:0] addr = '0;
   logic       we = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       ack = 1'b0;
   logic       ack_ch = 1'b0;
   logic [1:0] irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ext_irq_ctrl u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_i       (pin),
      .glb_ie_i    (gie),
      .reg_addr_i  (addr),
      .reg_we_i    (we),
      .reg_wdata_i (wdata),
      .reg_rdata_o (rdata),
      .ack_i       (ack),
      .ack_ch_i    (ack_ch),
      .irq_o       (irq)
   );

   typedef struct {
      string      req;
      bit         is_rd;
      logic [7:0] exp;
   } item_t;

   item_t sb[$];

   // monitor: pops expectations and compares against the ports
   initial begin
      forever begin
         @(negedge clk);
         #2;
         while (sb.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb.pop_front();
            act = it.is_rd ? rdata : {6'b0, irq};
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s %s actual=%h expected=%h", it.req,
                        it.is_rd ? "rdata" : "irq", act, it.exp);
            end
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic exp_rd(input logic [1:0] a, input logic [7:0] e, input string r);
      item_t it;
      @(negedge clk);
      addr = a;
      it.req = r; it.is_rd = 1'b1; it.exp = e;
      sb.push_back(it);
   endtask

   task automatic exp_irq(input logic [1:0] e, input string r);
      item_t it;
      @(negedge clk);
      it.req = r; it.is_rd = 1'b0; it.exp = {6'b0, e};
      sb.push_back(it);
   endtask

   task automatic set_pin(input int ch, input logic v);
      @(negedge clk);
      pin[ch] = v;
      step(4);
   endtask

   task automatic pulse_ack(input logic ch);
      @(negedge clk);
      ack = 1'b1; ack_ch = ch;
      @(negedge clk);
      ack = 1'b0;
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(2);
      // R1 reset state
      exp_rd(2'd0, 8'h00, "R1");
      exp_rd(2'd1, 8'h00, "R1");
      exp_rd(2'd2, 8'h00, "R1");
      exp_irq(2'b00, "R1");

      // ch0 any change, ch1 falling edge; both unmasked, global enable on
      wr(2'd0, 8'h09);
      wr(2'd1, 8'h03);
      gie = 1'b1;
      exp_rd(2'd0, 8'h09, "R8");
      exp_rd(2'd2, 8'h00, "R3");

      // R3 both directions set the flag
      set_pin(0, 1'b0);
      exp_rd(2'd2, 8'h01, "R3");
      exp_irq(2'b01, "R3");
      wr(2'd2, 8'h01);
      exp_rd(2'd2, 8'h00, "R7");
      set_pin(0, 1'b1);
      exp_rd(2'd2, 8'h01, "R3");
      wr(2'd2, 8'h01);

      // R4 falling sets, rising does not
      set_pin(1, 1'b0);
      exp_rd(2'd2, 8'h02, "R4");
      exp_irq(2'b10, "R4");
      wr(2'd2, 8'h02);
      set_pin(1, 1'b1);
      exp_rd(2'd2, 8'h00, "R4");

      // R7 zero bits leave flags alone
      set_pin(1, 1'b0);
      wr(2'd2, 8'h00);
      exp_rd(2'd2, 8'h02, "R7");
      wr(2'd2, 8'h01);
      exp_rd(2'd2, 8'h02, "R7");

      // R6 gating by mask and global enable
      wr(2'd1, 8'h01);
      exp_irq(2'b00, "R6");
      exp_rd(2'd2, 8'h02, "R6");
      wr(2'd1, 8'h03);
      @(negedge clk); gie = 1'b0;
      exp_irq(2'b00, "R6");
      @(negedge clk); gie = 1'b1;
      exp_irq(2'b10, "R6");

      // R9 acknowledge clears only the named channel
      set_pin(0, 1'b0);
      exp_rd(2'd2, 8'h03, "R9");
      pulse_ack(1'b1);
      exp_rd(2'd2, 8'h01, "R9");
      pulse_ack(1'b0);
      exp_rd(2'd2, 8'h00, "R9");
      set_pin(0, 1'b1);
      wr(2'd2, 8'h01);

      // R5 ch1 rising edge: rise sets, fall does not
      wr(2'd0, 8'h0D);
      set_pin(1, 1'b1);
      exp_rd(2'd2, 8'h02, "R5");
      wr(2'd2, 8'h02);
      set_pin(1, 1'b0);
      exp_rd(2'd2, 8'h00, "R5");

      // R10 acknowledge in the same cycle as a new rising edge
      set_pin(1, 1'b1);
      set_pin(1, 1'b0);
      exp_rd(2'd2, 8'h02, "R10");
      @(negedge clk); pin[1] = 1'b1;
      @(negedge clk);
      @(negedge clk); ack = 1'b1; ack_ch = 1'b1;
      @(negedge clk); ack = 1'b0;
      step(2);
      exp_rd(2'd2, 8'h02, "R10");
      wr(2'd2, 8'h02);

      // R2 ch0 low level, not latched
      wr(2'd0, 8'h0C);
      exp_irq(2'b00, "R2");
      @(negedge clk); pin[0] = 1'b0;
      step(3);
      exp_irq(2'b01, "R2");
      exp_rd(2'd2, 8'h00, "R2");
      @(negedge clk); pin[0] = 1'b1;
      step(3);
      exp_irq(2'b00, "R2");

      // R8 reserved bits read zero
      wr(2'd1, 8'hFF);
      exp_rd(2'd1, 8'h03, "R8");
      wr(2'd0, 8'hFF);
      exp_rd(2'd0, 8'h0F, "R8");
      wr(2'd2, 8'hFF);
      exp_rd(2'd2, 8'h00, "R8");

      step(3);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule